// File: doc/BRIEF.md
# Double-Buffered Byte and Serial Loaded Converter Code Register

This block is the digital front end of a 16-bit voltage-output converter. A host writes to it over an 8-bit bus with an active-low chip select and an active-low write strobe. Three active-low select lines decide what each write does. One select loads the low byte of a 16-bit input word. Another loads the high byte. The third copies the input word into the output register, which holds the code that drives the converter. When the low-byte and high-byte selects are both low, the block is in serial mode. Each write then shifts one bit, taken from bus bit 0, into the input word.

All control inputs are sampled by a system clock. A write takes effect when the strobe returns high. The block acts on the controls and bus as they stood at the last clock edge where the strobe was still low. An active-low clear empties the input word and puts the output register at mid-scale. A static strap selects unipolar handling. In that mode the MSB of the output code is inverted, so a cleared register reads as zero.

Top module: `dac_code_loader`

## Requirements
- R1: While `rstN` is low, and after it is released, the input word is 0 and the stored output code is 16'h8000, so `dacCode` reads 16'h8000 when `unipolar` is 0.
- R2: A write with `csN` low, `loSelN` low and `hiSelN` high loads `busIn` into bits 7..0 of the input word.
- R3: A write with `csN` low, `hiSelN` low and `loSelN` high loads `busIn` into bits 15..8 of the input word.
- R4: A write with `csN`, `loSelN` and `hiSelN` all low shifts the input word left by one bit and places `busIn[0]` in bit 0. Sixteen such writes deliver a word MSB first.
- R5: A write with `csN` low and `xferN` low copies the input word into the output register. If the same write also loads a byte or shifts a bit, the copy takes the updated word. The new code appears one clock edge after the first edge that samples `wrN` high.
- R6: A write strobe with `csN` high, or with no select low, changes neither the input word nor `dacCode`.
- R7: Any edge that samples `clrN` low sets the input word to 0 and the output register to 16'h8000 on the next edge. Clear overrides a write that completes at the same edge.
- R8: When `unipolar` is 1, `dacCode` equals the stored code with bit 15 inverted. A cleared register therefore reads 16'h0000, and a transferred word 16'h1234 reads 16'h9234.
- R9: The stored code changes only through a transfer or a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Chip select, active low |
| wrN | input | 1 | Write strobe, active low; acts on its rising edge |
| loSelN | input | 1 | Low-byte select, active low |
| hiSelN | input | 1 | High-byte select, active low |
| xferN | input | 1 | Transfer to output register, active low |
| clrN | input | 1 | Clear, active low |
| unipolar | input | 1 | 1 = invert output MSB (static strap) |
| busIn | input | 8 | Write data; bit 0 is the serial input |
| dacCode | output | 16 | Converter code |

## Verification
On every cycle, the assertions check four things:
- the byte-load and shift strobes never fire together;
- no strobe fires unless chip select was low during the strobe;
- each serial shift moves the word by exactly one bit;
- a clear always yields mid-scale and an empty word, and the stored code holds whenever there is no transfer or clear.

Only the bench scenarios can show the end-to-end results. These are that byte pairs and 16-bit serial streams arrive at `dacCode` with the right value and bit order, and that updated words pass through a transfer on the same write. They also cover clear winning over a simultaneous write and the unipolar MSB inversion. The bench model follows the sampled pins on every clock, so it also checks the one-edge latency after the strobe rises.

// File: rtl/dac_code_pkg.sv
package dac_code_pkg;
  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic shiftIn;
    logic xfer;
    logic clear;
  } ldStrobe_t;
endpackage

// File: rtl/dac_code_ctrl.sv
module dac_code_ctrl
  import dac_code_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             wrN,
  input  logic             loSelN,
  input  logic             hiSelN,
  input  logic             xferN,
  input  logic             clrN,
  input  logic [BUS_W-1:0] busIn,
  output ldStrobe_t        strobe,
  output logic [BUS_W-1:0] busHeld
);
  // stage one: latest sample; stage two: the sample before it
  logic             csA, wrA, loA, hiA, xfA, clrA;
  logic             csB, wrB, loB, hiB, xfB;
  logic [BUS_W-1:0] busA, busB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csA <= 1'b1; wrA <= 1'b1; loA <= 1'b1; hiA <= 1'b1; xfA <= 1'b1; clrA <= 1'b1;
      csB <= 1'b1; wrB <= 1'b1; loB <= 1'b1; hiB <= 1'b1; xfB <= 1'b1;
      busA <= '0;
      busB <= '0;
    end else begin
      csA <= csN; wrA <= wrN; loA <= loSelN; hiA <= hiSelN; xfA <= xferN; clrA <= clrN;
      csB <= csA; wrB <= wrA; loB <= loA; hiB <= hiA; xfB <= xfA;
      busA <= busIn;
      busB <= busA;
    end
  end

  logic writeDone;
  assign writeDone = wrA && !wrB && !csB;
  assign busHeld   = busB;

  always_comb begin
    strobe = '0;
    if (!clrA) begin
      strobe.clear = 1'b1;
    end else if (writeDone) begin
      strobe.loadLo  = !loB && hiB;
      strobe.loadHi  = !hiB && loB;
      strobe.shiftIn = !loB && !hiB;
      strobe.xfer    = !xfB;
    end
  end

  // R4: one write is a low-byte load, a high-byte load or a shift, never two of them
  assert_one_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.loadLo, strobe.loadHi, strobe.shiftIn}));

  // R6: every write strobe needs chip select low during the strobe
  assert_cs_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadLo || strobe.loadHi || strobe.shiftIn || strobe.xfer) |-> !$past(csN, 2));
endmodule

// File: rtl/dac_code_datapath.sv
module dac_code_datapath
  import dac_code_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ldStrobe_t            strobe,
  input  logic [BUS_W-1:0]     busHeld,
  input  logic                 unipolar,
  output logic [2*BUS_W-1:0]   dacCode
);
  localparam int WORD_W = 2 * BUS_W;
  localparam int LANES  = 2;
  localparam logic [WORD_W-1:0] MID_CODE = {1'b1, {(WORD_W-1){1'b0}}};

  logic [WORD_W-1:0] inWord, nextWord, dacReg;
  logic [LANES-1:0]  laneLoad;

  assign laneLoad = {strobe.loadHi, strobe.loadLo};

  always_comb begin
    nextWord = inWord;
    if (strobe.shiftIn) nextWord = {inWord[WORD_W-2:0], busHeld[0]};
  end

  for (genvar g = 0; g < LANES; g++) begin : gLane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                inWord[g*BUS_W +: BUS_W] <= '0;
      else if (strobe.clear)    inWord[g*BUS_W +: BUS_W] <= '0;
      else if (laneLoad[g])     inWord[g*BUS_W +: BUS_W] <= busHeld;
      else if (strobe.shiftIn)  inWord[g*BUS_W +: BUS_W] <= nextWord[g*BUS_W +: BUS_W];
    end
  end

  logic [WORD_W-1:0] xferWord;
  always_comb begin
    xferWord = nextWord;
    if (strobe.loadLo) xferWord[BUS_W-1:0]      = busHeld;
    if (strobe.loadHi) xferWord[WORD_W-1:BUS_W] = busHeld;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             dacReg <= MID_CODE;
    else if (strobe.clear) dacReg <= MID_CODE;
    else if (strobe.xfer)  dacReg <= xferWord;
  end

  assign dacCode = {dacReg[WORD_W-1] ^ unipolar, dacReg[WORD_W-2:0]};

  // R9: stored code only moves on transfer or clear
  assert_hold_code_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.xfer || strobe.clear) |=> $stable(dacReg));

  // R7: clear lands on mid-scale and an empty word
  assert_clear_mid_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (dacReg == MID_CODE) && (inWord == '0));

  // R4: a shift moves the word one place and appends the serial bit
  assert_shift_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftIn |=> inWord == {$past(inWord[WORD_W-2:0]), $past(busHeld[0])});
endmodule

// File: rtl/dac_code_loader.sv
module dac_code_loader
  import dac_code_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               csN,
  input  logic               wrN,
  input  logic               loSelN,
  input  logic               hiSelN,
  input  logic               xferN,
  input  logic               clrN,
  input  logic               unipolar,
  input  logic [BUS_W-1:0]   busIn,
  output logic [2*BUS_W-1:0] dacCode
);
  ldStrobe_t        strobe;
  logic [BUS_W-1:0] busHeld;

  dac_code_ctrl #(.BUS_W(BUS_W)) uCtrl (
    .clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .loSelN(loSelN),
    .hiSelN(hiSelN), .xferN(xferN), .clrN(clrN), .busIn(busIn),
    .strobe(strobe), .busHeld(busHeld)
  );

  dac_code_datapath #(.BUS_W(BUS_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busHeld(busHeld),
    .unipolar(unipolar), .dacCode(dacCode)
  );
endmodule

// File: tb/sim_dac_code_loader.sv
module sim_dac_code_loader;
  logic clk = 0, rstN = 0;
  logic csN = 1, wrN = 1, loSelN = 1, hiSelN = 1, xferN = 1, clrN = 1, unipolar = 0;
  logic [7:0]  busIn = 0;
  logic [15:0] dacCode;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dac_code_loader u0 (.clk(clk), .rstN(rstN), .csN(csN), .wrN(wrN), .loSelN(loSelN),
    .hiSelN(hiSelN), .xferN(xferN), .clrN(clrN), .unipolar(unipolar), .busIn(busIn),
    .dacCode(dacCode));

  // behavioural reference: pin samples from the last two edges
  int mWord = 0, mCode = 32768;
  int p1[7], p2[7];   // cs, wr, lo, hi, xf, clr, bus
  initial begin p1 = '{1,1,1,1,1,1,0}; p2 = '{1,1,1,1,1,1,0}; end

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mWord = 0; mCode = 32768;
      p1 = '{1,1,1,1,1,1,0}; p2 = '{1,1,1,1,1,1,0};
    end else begin
      if (p1[5] == 0) begin
        mWord = 0; mCode = 32768;
      end else if (p1[1] == 1 && p2[1] == 0 && p2[0] == 0) begin
        if (p2[2] == 0 && p2[3] == 0)      mWord = ((mWord * 2) % 65536) + (p2[6] % 2);
        else if (p2[2] == 0)               mWord = (mWord / 256) * 256 + p2[6];
        else if (p2[3] == 0)               mWord = p2[6] * 256 + (mWord % 256);
        if (p2[4] == 0) mCode = mWord;
      end
      p2 = p1;
      p1 = '{int'(csN), int'(wrN), int'(loSelN), int'(hiSelN), int'(xferN), int'(clrN), int'(busIn)};
    end
  end

  function automatic int shownCode();
    return unipolar ? (mCode ^ 32768) : mCode;
  endfunction

  always @(negedge clk) if (rstN && !done) begin
    checks++;
    if (int'(dacCode) != shownCode()) begin
      fails++;
      $display("FAIL R9 per-cycle model: actual %h expected %h", dacCode, shownCode()[15:0]);
    end
  end

  task automatic check(input string tag, input logic [15:0] exp);
    checks++;
    if (dacCode !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, dacCode, exp);
    end
  endtask

  task automatic hostWrite(input logic c, input logic lo, input logic hi, input logic xf,
                           input logic [7:0] d);
    @(negedge clk);
    csN = c; loSelN = lo; hiSelN = hi; xferN = xf; busIn = d; wrN = 0;
    repeat (2) @(negedge clk);
    wrN = 1;
    @(negedge clk);
    csN = 1; loSelN = 1; hiSelN = 1; xferN = 1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset mid-scale", 16'h8000);
    rstN = 1;
    repeat (2) @(negedge clk);
    check("R1 after release", 16'h8000);

    hostWrite(0, 0, 1, 1, 8'h34);
    check("R2 low byte not yet transferred", 16'h8000);
    hostWrite(0, 1, 0, 1, 8'h12);
    hostWrite(0, 1, 1, 0, 8'h00);
    check("R5 transfer of R2/R3 bytes", 16'h1234);

    hostWrite(0, 0, 1, 0, 8'hEE);
    check("R5 flow-through with R2 load", 16'h12EE);
    hostWrite(0, 1, 0, 0, 8'h7A);
    check("R3 high byte flow-through", 16'h7AEE);

    hostWrite(1, 0, 1, 0, 8'h55);
    check("R6 chip select high ignored", 16'h7AEE);
    hostWrite(0, 1, 1, 1, 8'h99);
    hostWrite(0, 1, 1, 0, 8'h00);
    check("R6 no select leaves word", 16'h7AEE);

    for (int i = 15; i >= 0; i--) hostWrite(0, 0, 0, 1, {7'd0, 1'(16'hA5C3 >> i)});
    hostWrite(0, 1, 1, 0, 8'h00);
    check("R4 serial MSB first", 16'hA5C3);

    unipolar = 1;
    @(negedge clk);
    check("R8 unipolar inverts MSB", 16'h25C3);
    hostWrite(0, 0, 1, 1, 8'h34);
    hostWrite(0, 1, 0, 0, 8'h12);
    check("R8 unipolar 1234", 16'h9234);

    @(negedge clk); clrN = 0; @(negedge clk); clrN = 1;
    repeat (2) @(negedge clk);
    check("R7 R8 unipolar clear reads zero", 16'h0000);
    unipolar = 0;
    @(negedge clk);
    check("R7 clear mid-scale", 16'h8000);
    hostWrite(0, 1, 1, 0, 8'h00);
    check("R7 input word cleared", 16'h0000);

    hostWrite(0, 0, 1, 1, 8'h11);
    @(negedge clk);
    csN = 0; hiSelN = 0; xferN = 0; busIn = 8'h66; wrN = 0;
    repeat (2) @(negedge clk);
    wrN = 1; clrN = 0;
    @(negedge clk);
    csN = 1; hiSelN = 1; xferN = 1; clrN = 1;
    repeat (2) @(negedge clk);
    check("R7 clear beats same-edge write", 16'h8000);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule